// File: doc/BRIEF.md
# Flash Program/Erase Error Guard

This block watches over flash programming and erasing. Software writes a control register (program, erase, program-verify and erase-verify bits) and block-select registers through a simple write port. The guard passes masked program and erase enables to the flash controller. An operation is active whenever the program bit or the erase bit is set. If the processor misbehaves while an operation is active, the guard latches a sticky error flag. The misbehaviour is a flash read, the start of exception handling, entry to sleep or software standby, or release of the bus.

The error flag raises an abort output at once, and it stays latched until a watchdog reset, a hardware standby or the reset pin. While the flag is set, the register contents are kept and stay writable, but software cannot set the program or erase bit again. The verify bits can still be set, so verify modes stay reachable. Entering software standby while the flag is set wipes every register to zero and leaves the flag untouched.

Top module: `flash_err_guard`

## Requirements
- R1: While `rst_n` is low, the error flag, the abort output, both enables and all registers are zero.
- R2: When an operation is active (control bit 0 = program or bit 1 = erase set) and any of `ev_read`, `ev_exc`, `ev_sleep`, `ev_busrel` or `sw_stby` is high, the error flag is 1 after the next clock edge. Several events in one cycle act as one.
- R3: Event strobes that arrive while neither control bit 0 nor bit 1 is set leave the error flag at 0.
- R4: `ev_nmi` never sets the error flag.
- R5: `abort` equals the error flag. `prog_en` and `erase_en` follow control bits 0 and 1 but are 0 while the flag is set.
- R6: Entering the error state does not alter the control or block-select registers.
- R7: While the flag is set, a control write may clear bits 0 and 1 but cannot set them. Bits 2 (program-verify), 3 (erase-verify) and 7:4 take the written value.
- R8: While the flag is set, the block-select registers accept writes as usual.
- R9: `sw_stby` while the flag is set clears all registers and keeps the flag at 1. While an operation is active without the flag, it sets the flag and keeps the registers.
- R10: `wdt_rst` or `hw_stby` clears the flag and all registers at the next edge. Nothing else clears the flag.
- R11: Outside the error state, a write with `wr_sel` 0 loads the control register and `wr_sel` 1 or 2 loads block-select 0 or 1. `wr_sel` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Pin reset, asynchronous, active low |
| wdt_rst | input | 1 | Watchdog reset request |
| hw_stby | input | 1 | Hardware standby, clears like reset |
| sw_stby | input | 1 | Software standby entry strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 block-select 0, 2 block-select 1 |
| wr_data | input | 8 | Write data |
| ev_read | input | 1 | Flash read, vector read or fetch |
| ev_exc | input | 1 | Non-reset exception handling starts |
| ev_sleep | input | 1 | Sleep instruction executed |
| ev_busrel | input | 1 | Bus granted to another master |
| ev_nmi | input | 1 | Non-maskable interrupt request (ignored) |
| err_flag | output | 1 | Sticky error flag, read-only |
| abort | output | 1 | Stops programming or erasing |
| prog_en | output | 1 | Masked program enable |
| erase_en | output | 1 | Masked erase enable |
| ctl_q | output | 8 | Control register contents |
| blk_q | output | 16 | Block-select registers, block 1 in the upper byte |

## Verification
A control write and a trigger event can fall in the same cycle. The bench drives a write that clears the program bit in the same cycle as several trigger strobes. The write must land because the flag was still clear, and the flag must latch because the operation was active before the edge. Software standby and the error state also meet in one cycle. Standby is given both while the flag is already set, which should wipe the registers, and while it is not yet set, which should latch the flag and keep the registers. A behavioural model updated every clock judges each of these cases.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int CTL_PROG  = 0;
  localparam int CTL_ERASE = 1;
  localparam int CTL_PVFY  = 2;
  localparam int CTL_EVFY  = 3;
endpackage

// File: rtl/fg_trigger.sv
module fg_trigger (
  input  logic prog_bit,
  input  logic erase_bit,
  input  logic ev_read,
  input  logic ev_exc,
  input  logic ev_sleep,
  input  logic ev_busrel,
  output logic active,
  output logic trig
);
  logic any_ev;

  always_comb begin
    active = prog_bit | erase_bit;
    any_ev = ev_read | ev_exc | ev_sleep | ev_busrel;
    trig   = active & any_ev;
  end
endmodule

// File: rtl/fg_err_state.sv
module fg_err_state (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_clr,
  input  logic trig,
  output logic err
);
  logic err_nxt;
  logic err_ld;

  always_comb begin
    err_nxt = err;
    err_ld  = 1'b0;
    if (hw_clr) begin
      err_nxt = 1'b0;
      err_ld  = 1'b1;
    end else if (trig && !err) begin
      err_nxt = 1'b1;
      err_ld  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err <= 1'b0;
    else if (err_ld) err <= err_nxt;
  end

  a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !hw_clr |=> err);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !hw_clr |=> err);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !err);
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !err && !trig |=> !err);
endmodule

// File: rtl/fg_regs.sv
module fg_regs #(
  parameter int DW      = 8,
  parameter int NUM_BLK = 2,
  parameter int SEL_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hw_clr,
  input  logic                  sw_wipe,
  input  logic                  err,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [DW-1:0]         wr_data,
  output logic [DW-1:0]         ctl_q,
  output logic [NUM_BLK*DW-1:0] blk_q
);
  import fg_pkg::*;

  logic          wipe;
  logic [DW-1:0] ctl_nxt;
  logic          ctl_ld;

  assign wipe = hw_clr | sw_wipe;

  always_comb begin
    ctl_nxt = ctl_q;
    ctl_ld  = 1'b0;
    if (wipe) begin
      ctl_nxt = '0;
      ctl_ld  = 1'b1;
    end else if (wr_en && wr_sel == SEL_W'(0)) begin
      ctl_nxt = wr_data;
      ctl_ld  = 1'b1;
      if (err) begin
        ctl_nxt[CTL_PROG]  = wr_data[CTL_PROG]  & ctl_q[CTL_PROG];
        ctl_nxt[CTL_ERASE] = wr_data[CTL_ERASE] & ctl_q[CTL_ERASE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ld) ctl_q <= ctl_nxt;
  end

  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_blk
    logic [DW-1:0] b_q;
    logic [DW-1:0] b_nxt;
    logic          b_ld;

    always_comb begin
      b_nxt = b_q;
      b_ld  = 1'b0;
      if (wipe) begin
        b_nxt = '0;
        b_ld  = 1'b1;
      end else if (wr_en && wr_sel == SEL_W'(gi + 1)) begin
        b_nxt = wr_data;
        b_ld  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= '0;
      else if (b_ld) b_q <= b_nxt;
    end

    assign blk_q[gi*DW +: DW] = b_q;

    a_r9_blk_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wipe |=> b_q == '0);
  end

  a_r7_no_prog_set: assert property (@(posedge clk) disable iff (!rst_n)
    err && !ctl_q[CTL_PROG] |=> !ctl_q[CTL_PROG]);
  a_r7_no_erase_set: assert property (@(posedge clk) disable iff (!rst_n)
    err && !ctl_q[CTL_ERASE] |=> !ctl_q[CTL_ERASE]);
  a_r9_ctl_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wipe |=> ctl_q == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !wipe |=> $stable(ctl_q));
endmodule

// File: rtl/flash_err_guard.sv
module flash_err_guard #(
  parameter int DW      = 8,
  parameter int NUM_BLK = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wdt_rst,
  input  logic                  hw_stby,
  input  logic                  sw_stby,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [DW-1:0]         wr_data,
  input  logic                  ev_read,
  input  logic                  ev_exc,
  input  logic                  ev_sleep,
  input  logic                  ev_busrel,
  input  logic                  ev_nmi,
  output logic                  err_flag,
  output logic                  abort,
  output logic                  prog_en,
  output logic                  erase_en,
  output logic [DW-1:0]         ctl_q,
  output logic [NUM_BLK*DW-1:0] blk_q
);
  import fg_pkg::*;

  localparam int SEL_W = 2;

  logic [1:0] rst_sync;
  logic       rst_i;
  logic       hw_clr;
  logic       sleep_any;
  logic       active;
  logic       trig;
  logic       err;
  logic       sw_wipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign hw_clr    = wdt_rst | hw_stby;
  assign sleep_any = ev_sleep | sw_stby;

  fg_trigger u_trig (
    .prog_bit  (ctl_q[CTL_PROG]),
    .erase_bit (ctl_q[CTL_ERASE]),
    .ev_read   (ev_read),
    .ev_exc    (ev_exc),
    .ev_sleep  (sleep_any),
    .ev_busrel (ev_busrel),
    .active    (active),
    .trig      (trig)
  );

  fg_err_state u_err (
    .clk    (clk),
    .rst_n  (rst_i),
    .hw_clr (hw_clr),
    .trig   (trig),
    .err    (err)
  );

  assign sw_wipe = sw_stby & err;

  fg_regs #(.DW(DW), .NUM_BLK(NUM_BLK), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_i),
    .hw_clr  (hw_clr),
    .sw_wipe (sw_wipe),
    .err     (err),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctl_q   (ctl_q),
    .blk_q   (blk_q)
  );

  assign err_flag = err;
  assign abort    = err;
  assign prog_en  = ctl_q[CTL_PROG]  & ~err;
  assign erase_en = ctl_q[CTL_ERASE] & ~err;

  a_r4_nmi_ignored: assert property (@(posedge clk) disable iff (!rst_i)
    ev_nmi && !err && !(active && (ev_read || ev_exc || sleep_any || ev_busrel))
    |=> !err_flag);
  a_r5_abort_on_trig: assert property (@(posedge clk) disable iff (!rst_i)
    trig && !hw_clr |=> abort && !prog_en && !erase_en);
  a_r3_idle_events: assert property (@(posedge clk) disable iff (!rst_i)
    !active && !err |=> !err_flag);
  a_r9_sws_latch: assert property (@(posedge clk) disable iff (!rst_i)
    sw_stby && active && !hw_clr |=> err_flag);
endmodule

// File: tb/sim_flash_err_guard.sv
`timescale 1ns/1ps
module sim_flash_err_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_rst = 0, hw_stby = 0, sw_stby = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic ev_read = 0, ev_exc = 0, ev_sleep = 0, ev_busrel = 0, ev_nmi = 0;
  logic err_flag, abort, prog_en, erase_en;
  logic [7:0] ctl_q;
  logic [15:0] blk_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_ctl, m_b0, m_b1, m_err;

  always #10 clk = ~clk;

  flash_err_guard u0 (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ev_read(ev_read), .ev_exc(ev_exc),
    .ev_sleep(ev_sleep), .ev_busrel(ev_busrel), .ev_nmi(ev_nmi), .err_flag(err_flag),
    .abort(abort), .prog_en(prog_en), .erase_en(erase_en), .ctl_q(ctl_q), .blk_q(blk_q)
  );

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "err_flag", int'(err_flag), m_err);
    chk(tag, "abort", int'(abort), m_err);
    chk(tag, "prog_en", int'(prog_en), (m_ctl & 1) != 0 && m_err == 0);
    chk(tag, "erase_en", int'(erase_en), (m_ctl & 2) != 0 && m_err == 0);
    chk(tag, "ctl_q", int'(ctl_q), m_ctl);
    chk(tag, "blk0", int'(blk_q[7:0]), m_b0);
    chk(tag, "blk1", int'(blk_q[15:8]), m_b1);
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(string tag, bit we, int sel, int dat, bit rd, bit ex, bit sl,
                      bit br, bit nmi, bit sws, bit wdt, bit hws);
    bit act, trg;
    int nctl;
    wr_en = we; wr_sel = 2'(sel); wr_data = 8'(dat);
    ev_read = rd; ev_exc = ex; ev_sleep = sl; ev_busrel = br; ev_nmi = nmi;
    sw_stby = sws; wdt_rst = wdt; hw_stby = hws;
    @(posedge clk);
    if (wdt || hws) begin
      m_err = 0; m_ctl = 0; m_b0 = 0; m_b1 = 0;
    end else begin
      act = (m_ctl & 3) != 0;
      trg = act && (rd || ex || sl || br || sws);
      if (sws && m_err == 1) begin
        m_ctl = 0; m_b0 = 0; m_b1 = 0;
      end else if (we) begin
        if (sel == 0) begin
          nctl = dat;
          if (m_err == 1) nctl = (dat & 'hFC) | (dat & m_ctl & 3);
          m_ctl = nctl;
        end else if (sel == 1) m_b0 = dat;
        else if (sel == 2) m_b1 = dat;
      end
      if (trg) m_err = 1;
    end
    @(negedge clk);
    chk_all(tag);
    wr_en = 0; ev_read = 0; ev_exc = 0; ev_sleep = 0; ev_busrel = 0; ev_nmi = 0;
    sw_stby = 0; wdt_rst = 0; hw_stby = 0;
  endtask

  task automatic wr(string tag, int sel, int dat);
    step(tag, 1, sel, dat, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_ctl = 0; m_b0 = 0; m_b1 = 0; m_err = 0;
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1");

    // R11 normal writes
    wr("R11", 0, 'h01);
    wr("R11", 1, 'h5A);
    wr("R11", 2, 'hA5);
    wr("R11", 3, 'hFF);
    // R4 NMI during active program
    step("R4", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R3 events while idle
    wr("R3", 0, 'h00);
    step("R3", 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R2 erase, then read trigger; R5 R6
    wr("R2", 0, 'h32);
    step("R2", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 writes in error
    wr("R7", 0, 'h0F);
    wr("R7", 0, 'h00);
    wr("R7", 0, 'h0F);
    // R8 block writes in error
    wr("R8", 1, 'h11);
    wr("R8", 2, 'h22);
    // R9 software standby in error
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R10 sticky then watchdog clear
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R2 same-cycle write clearing program bit with several events
    wr("R2", 0, 'h01);
    step("R2", 1, 0, 'h00, 1, 1, 0, 1, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R9 software standby while active without flag
    wr("R9", 0, 'h03);
    wr("R9", 2, 'h77);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R2 each trigger on its own
    wr("R2", 0, 'h01);
    step("R2", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    wr("R2", 0, 'h02);
    step("R2", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    wr("R2", 0, 'h01);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R10 trigger and watchdog together: clear wins
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    wr("R10", 0, 'h01);
    step("R10", 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0);
    // R1 pin reset in the middle
    wr("R1", 1, 'h3C);
    step("R2", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_ctl = 0; m_b0 = 0; m_b1 = 0; m_err = 0;
    #1;
    chk_all("R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule